// File: doc/BRIEF.md
# Posted Write Packet Buffer

This block holds memory write transactions that a bridge has already accepted from one bus and will forward to the other bus later. Each transaction is stored as one address record followed by one or more data words, each with its byte enables. Several transactions can be resident at the same time. All of them share one byte budget, so the number that fits depends on how long their bursts are.

The input side takes a write burst beat by beat. It refuses a new transaction with a retry when there is no room for an address record plus one data word, or when the resident transaction limit is reached. It ends a burst early with a disconnect when the budget runs out or when the burst reaches its length boundary. The stored part is then closed as a complete transaction. The output side replays closed transactions in arrival order, one burst each, with a start marker on the address record and an end marker on the final data word.

Top module: `posted_wr_buf`

## Requirements
- R1: Storage is `BUF_BYTES/4` slots of 4 bytes each. Address records and data words each use one slot, taken from the same shared budget. The number of stored slots never exceeds this capacity.
- R2: A beat with `in_first_i=1` carries the address in `in_data_i`. It is accepted (`in_ready_o=1`) only if no burst is open, at least 2 slots are free, and fewer than `MAX_TXN` transactions are resident. Otherwise `in_retry_o=1`, `in_ready_o=0` and nothing is stored.
- R3: If an accepted data beat with `in_last_i=0` takes the last free slot, `in_disc_o=1` is raised on that beat and the transaction is closed with that word as its final word.
- R4: If an accepted data beat with `in_last_i=0` is the `MAX_BURST`-th data word of its burst, `in_disc_o=1` is raised and the transaction is closed there.
- R5: A beat with `in_last_i=1` that fills the last slot or reaches the burst boundary closes the transaction normally, with `in_disc_o=0`.
- R6: A data beat (`in_first_i=0`) presented while no burst is open is ignored: `in_ready_o=0` and nothing reaches the output.
- R7: The output replays slots in arrival order. An address record has `out_sop_o=1`, `out_eop_o=0` and `out_be_o=0`. A data word has `out_sop_o=0` and carries its stored byte enables. The final word of each transaction has `out_eop_o=1`. While `out_ready_i=0`, the output holds.
- R8: A transaction appears on the output only after it has been closed by a last beat or a disconnect.
- R9: A slot is freed when its word is taken at the output, and a transaction stops counting as resident when its final word is taken. This makes room for new transactions.
- R10: After reset, `out_valid_o=0`, all slots are free and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input beat present |
| in_first_i | input | 1 | Beat is an address record that starts a transaction |
| in_last_i | input | 1 | Beat is the final data word of the burst |
| in_data_i | input | 32 | Address (first beat) or write data |
| in_be_i | input | 4 | Byte enables of a data beat |
| in_ready_o | output | 1 | Beat is accepted this cycle |
| in_retry_o | output | 1 | Address beat refused; try again later |
| in_disc_o | output | 1 | Burst ended early on this accepted beat |
| out_valid_o | output | 1 | Output slot present |
| out_ready_i | input | 1 | Consumer takes the output slot |
| out_sop_o | output | 1 | Output slot is an address record |
| out_eop_o | output | 1 | Output slot is the final word of its transaction |
| out_data_o | output | 32 | Address or data of the output slot |
| out_be_o | output | 4 | Byte enables of the output slot |

## Verification
The bench builds the buffer with `BUF_BYTES=40`, giving 10 slots, with `MAX_TXN=3` and `MAX_BURST=6`. These small values make each limit reachable in a few beats. A long burst hits the boundary disconnect, the next burst hits the space disconnect, three short transactions hit the resident limit while slots are still free, and exact-fit last beats show the boundary and space cases without a disconnect. A final phase overlaps input bursts with a stalling output, so the buffer wraps and releases space while new transactions are admitted.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = 4;

  typedef struct packed {
    logic              sop;
    logic              eop;
    logic [BE_W-1:0]   be;
    logic [DATA_W-1:0] data;
  } pwb_slot_t;
endpackage

// File: rtl/pwb_ring.sv
module pwb_ring
  import pwb_pkg::*;
#(
  parameter  int unsigned DEPTH = 22,
  localparam int unsigned PW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  pwb_slot_t     push_slot_i,
  input  logic          pop_i,
  output pwb_slot_t     head_o,
  output logic [CW-1:0] free_o
);
  pwb_slot_t     mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] free_q;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= push_slot_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      free_q <= CW'(DEPTH);
    end else begin
      if (push_i) wr_q <= wrap_inc(wr_q);
      if (pop_i)  rd_q <= wrap_inc(rd_q);
      case ({push_i, pop_i})
        2'b10:   free_q <= free_q - 1'b1;
        2'b01:   free_q <= free_q + 1'b1;
        default: free_q <= free_q;
      endcase
    end
  end

  assign head_o = mem_q[rd_q];
  assign free_o = free_q;
endmodule

// File: rtl/pwb_admit.sv
module pwb_admit #(
  parameter  int unsigned DEPTH     = 22,
  parameter  int unsigned MAX_TXN   = 3,
  parameter  int unsigned MAX_BURST = 16,
  localparam int unsigned CW        = $clog2(DEPTH + 1),
  localparam int unsigned TW        = $clog2(MAX_TXN + 1),
  localparam int unsigned BW        = $clog2(MAX_BURST + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          in_first_i,
  input  logic          in_last_i,
  input  logic [CW-1:0] free_i,
  input  logic [TW-1:0] resident_i,
  output logic          ready_o,
  output logic          retry_o,
  output logic          disc_o,
  output logic          push_o,
  output logic          start_o,
  output logic          close_o,
  output logic          eop_o
);
  logic          open_q;
  logic [BW-1:0] beats_q;
  logic          can_start, data_beat, at_limit;

  // room for address record plus one data word
  assign can_start = !open_q && (free_i >= CW'(2)) && (resident_i < TW'(MAX_TXN));
  assign data_beat = in_valid_i && !in_first_i && open_q;
  assign at_limit  = (free_i == CW'(1)) || (beats_q == BW'(MAX_BURST - 1));

  assign start_o = in_valid_i && in_first_i && can_start;
  assign retry_o = in_valid_i && in_first_i && !can_start;
  assign ready_o = start_o || data_beat;
  assign push_o  = ready_o;
  assign close_o = data_beat && (in_last_i || at_limit);
  assign disc_o  = data_beat && !in_last_i && at_limit;
  assign eop_o   = close_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      beats_q <= '0;
    end else if (start_o) begin
      open_q  <= 1'b1;
      beats_q <= '0;
    end else if (data_beat) begin
      beats_q <= beats_q + 1'b1;
      if (close_o) open_q <= 1'b0;
    end
  end
endmodule

// File: rtl/posted_wr_buf.sv
module posted_wr_buf
  import pwb_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 88,
  parameter int unsigned MAX_TXN   = 3,
  parameter int unsigned MAX_BURST = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_first_i,
  input  logic              in_last_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [BE_W-1:0]   in_be_i,
  output logic              in_ready_o,
  output logic              in_retry_o,
  output logic              in_disc_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [BE_W-1:0]   out_be_o
);
  localparam int unsigned SLOTS = BUF_BYTES / 4;
  localparam int unsigned CW    = $clog2(SLOTS + 1);
  localparam int unsigned TW    = $clog2(MAX_TXN + 1);

  logic          push, pop, start, close, slot_eop, pop_end;
  logic [CW-1:0] free;
  logic [TW-1:0] resident_q, closed_q;
  pwb_slot_t     wr_slot, head;

  pwb_admit #(
    .DEPTH(SLOTS), .MAX_TXN(MAX_TXN), .MAX_BURST(MAX_BURST)
  ) i_admit (
    .clk_i, .rst_ni,
    .in_valid_i, .in_first_i, .in_last_i,
    .free_i(free), .resident_i(resident_q),
    .ready_o(in_ready_o), .retry_o(in_retry_o), .disc_o(in_disc_o),
    .push_o(push), .start_o(start), .close_o(close), .eop_o(slot_eop)
  );

  always_comb begin
    wr_slot.sop  = in_first_i;
    wr_slot.eop  = !in_first_i && slot_eop;
    wr_slot.be   = in_first_i ? '0 : in_be_i;
    wr_slot.data = in_data_i;
  end

  pwb_ring #(.DEPTH(SLOTS)) i_ring (
    .clk_i, .rst_ni,
    .push_i(push), .push_slot_i(wr_slot),
    .pop_i(pop), .head_o(head), .free_o(free)
  );

  // the open transaction is always the youngest, so any closed one is at the head
  assign out_valid_o = (closed_q != '0);
  assign pop         = out_valid_o && out_ready_i;
  assign pop_end     = pop && head.eop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resident_q <= '0;
      closed_q   <= '0;
    end else begin
      case ({start, pop_end})
        2'b10:   resident_q <= resident_q + 1'b1;
        2'b01:   resident_q <= resident_q - 1'b1;
        default: resident_q <= resident_q;
      endcase
      case ({close, pop_end})
        2'b10:   closed_q <= closed_q + 1'b1;
        2'b01:   closed_q <= closed_q - 1'b1;
        default: closed_q <= closed_q;
      endcase
    end
  end

  assign out_sop_o  = head.sop;
  assign out_eop_o  = head.eop;
  assign out_data_o = head.data;
  assign out_be_o   = head.be;
endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
  parameter int unsigned BUF_BYTES = 88,
  parameter int unsigned MAX_TXN   = 3
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_first_i,
  input logic        in_last_i,
  input logic        in_ready_o,
  input logic        in_retry_o,
  input logic        in_disc_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic        out_sop_o,
  input logic        out_eop_o,
  input logic [31:0] out_data_o
);
  localparam int unsigned SLOTS = BUF_BYTES / 4;

  logic acc, pop, open_q, want_sop_q;
  int   occ_q, res_q;

  assign acc = in_valid_i && in_ready_o;
  assign pop = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q      <= 0;
      res_q      <= 0;
      open_q     <= 1'b0;
      want_sop_q <= 1'b1;
    end else begin
      occ_q <= occ_q + (acc ? 1 : 0) - (pop ? 1 : 0);
      res_q <= res_q + ((acc && in_first_i) ? 1 : 0) - ((pop && out_eop_o) ? 1 : 0);
      if (acc && in_first_i) open_q <= 1'b1;
      else if (acc && (in_last_i || in_disc_o)) open_q <= 1'b0;
      if (pop) want_sop_q <= out_eop_o;
    end
  end

  a_r1_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= SLOTS);
  a_r2_retry_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_retry_o |-> (!in_ready_o && in_first_i && in_valid_i));
  a_r2_txn_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && in_first_i) |-> (res_q < MAX_TXN));
  a_r3_disc_data_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_disc_o |-> (in_ready_o && !in_first_i && !in_last_i));
  a_r6_orphan_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_first_i && !open_q) |-> !in_ready_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_eop_o)));
  a_r7_sop_framing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_sop_o == want_sop_q));
endmodule

bind posted_wr_buf pwb_chk #(.BUF_BYTES(BUF_BYTES), .MAX_TXN(MAX_TXN)) i_pwb_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .in_valid_i(in_valid_i), .in_first_i(in_first_i), .in_last_i(in_last_i),
  .in_ready_o(in_ready_o), .in_retry_o(in_retry_o), .in_disc_o(in_disc_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_sop_o(out_sop_o), .out_eop_o(out_eop_o), .out_data_o(out_data_o)
);

// File: tb/test_posted_wr_buf.sv
module test_posted_wr_buf;
  localparam int BUF_BYTES = 40;
  localparam int MAX_TXN   = 3;
  localparam int MAX_BURST = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 1'b0, in_first_i = 1'b0, in_last_i = 1'b0;
  logic [31:0] in_data_i = '0;
  logic [3:0]  in_be_i = '0;
  logic in_ready_o, in_retry_o, in_disc_o;
  logic out_valid_o, out_sop_o, out_eop_o;
  logic out_ready_i = 1'b0;
  logic [31:0] out_data_o;
  logic [3:0]  out_be_o;

  always #4 clk_i = ~clk_i;

  posted_wr_buf #(.BUF_BYTES(BUF_BYTES), .MAX_TXN(MAX_TXN), .MAX_BURST(MAX_BURST)) i_posted_wr_buf (
    .clk_i, .rst_ni, .in_valid_i, .in_first_i, .in_last_i, .in_data_i, .in_be_i,
    .in_ready_o, .in_retry_o, .in_disc_o, .out_valid_o, .out_ready_i,
    .out_sop_o, .out_eop_o, .out_data_o, .out_be_o
  );

  int total = 0, bad = 0;
  bit done = 0;
  bit pace = 0;
  logic [37:0] exp_q[$];   // {sop, eop, be, data}

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    #2;
    if (rst_ni && out_valid_o && out_ready_i) begin
      if (exp_q.size() == 0)
        check(0, "R7 unexpected output", {26'd0, out_sop_o, out_eop_o, out_be_o, out_data_o}, 0);
      else begin
        logic [37:0] e;
        e = exp_q.pop_front();
        check({out_sop_o, out_eop_o, out_be_o, out_data_o} == e, "R7 output order/markers",
              {26'd0, out_sop_o, out_eop_o, out_be_o, out_data_o}, {26'd0, e});
      end
    end
  end

  always @(negedge clk_i) if (pace) out_ready_i <= ($urandom_range(0, 2) != 0);

  task automatic do_beat(input bit first, input bit last, input logic [31:0] d, input logic [3:0] be,
                         output bit rdy, output bit ret, output bit dis);
    @(negedge clk_i);
    in_valid_i = 1; in_first_i = first; in_last_i = last; in_data_i = d; in_be_i = be;
    #1;
    rdy = in_ready_o; ret = in_retry_o; dis = in_disc_o;
    @(posedge clk_i); #1;
    in_valid_i = 0; in_first_i = 0; in_last_i = 0;
  endtask

  task automatic send_txn(input logic [31:0] addr, input int n, input bit persist,
                          output int acc, output bit retried, output bit disc);
    bit rdy, ret, dis;
    acc = 0; retried = 0; disc = 0;
    forever begin
      do_beat(1, 0, addr, 4'h0, rdy, ret, dis);
      if (rdy) break;
      if (ret) retried = 1;
      if (!persist) return;
    end
    exp_q.push_back({1'b1, 1'b0, 4'h0, addr});
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      logic [3:0]  be;
      d  = {addr[15:0], 16'(i)};
      be = 4'hF ^ 4'(i);
      do_beat(0, i == n - 1, d, be, rdy, ret, dis);
      if (!rdy) begin
        check(0, "R6 open burst data refused", 0, 1);
        return;
      end
      exp_q.push_back({1'b0, (i == n - 1) || dis, be, d});
      acc++;
      if (dis) begin disc = 1; break; end
    end
  endtask

  task automatic drain();
    out_ready_i = 1;
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(posedge clk_i);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i); #1;
    check(exp_q.size() == 0, "R9 drain complete", exp_q.size(), 0);
    check(out_valid_o == 0, "R9 empty after drain", out_valid_o, 0);
    out_ready_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int acc;
    bit ret, dis, rdy;
    repeat (3) @(posedge clk_i);
    #1;
    check(out_valid_o == 0, "R10 reset out_valid", out_valid_o, 0);
    check(in_retry_o == 0 && in_disc_o == 0, "R10 reset flags", {in_retry_o, in_disc_o}, 0);
    rst_ni = 1;
    repeat (2) @(posedge clk_i);

    // R6: data with no open burst
    do_beat(0, 1, 32'hDEAD0000, 4'hF, rdy, ret, dis);
    check(rdy == 0, "R6 orphan data refused", rdy, 0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); #1;
    check(out_valid_o == 0, "R6 orphan not stored", out_valid_o, 0);

    // R8: open burst invisible until closed
    do_beat(1, 0, 32'h0000_0A00, 4'h0, rdy, ret, dis);
    exp_q.push_back({1'b1, 1'b0, 4'h0, 32'h0000_0A00});
    do_beat(0, 0, 32'h1111_2222, 4'h3, rdy, ret, dis);
    exp_q.push_back({1'b0, 1'b0, 4'h3, 32'h1111_2222});
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); #1;
    check(out_valid_o == 0, "R8 open burst hidden", out_valid_o, 0);
    do_beat(0, 1, 32'h3333_4444, 4'hC, rdy, ret, dis);
    exp_q.push_back({1'b0, 1'b1, 4'hC, 32'h3333_4444});
    @(negedge clk_i); #1;
    check(out_valid_o == 1, "R8 closed burst visible", out_valid_o, 1);
    drain();

    // R4: boundary disconnect (10 slots, 6-word bursts)
    send_txn(32'h0000_0100, 8, 0, acc, ret, dis);
    check(acc == 6 && dis, "R4 boundary disconnect", {acc, 31'd0, dis}, {32'd6, 32'd1});
    // R3: space disconnect (3 slots left)
    send_txn(32'h0000_0200, 3, 0, acc, ret, dis);
    check(acc == 2 && dis, "R3 space disconnect", {acc, 31'd0, dis}, {32'd2, 32'd1});
    // R1/R2: full -> retry
    send_txn(32'h0000_0300, 1, 0, acc, ret, dis);
    check(ret && acc == 0, "R2 retry when full", {31'd0, ret, acc}, {32'd1, 32'd0});
    drain();

    // R2: resident limit with free slots
    for (int k = 0; k < 3; k++) begin
      send_txn(32'h0000_0400 + 32'(k), 1, 0, acc, ret, dis);
      check(acc == 1 && !ret && !dis, "R2 small txn accepted", acc, 1);
    end
    send_txn(32'h0000_0500, 1, 0, acc, ret, dis);
    check(ret && acc == 0, "R2 retry at txn limit", {31'd0, ret, acc}, {32'd1, 32'd0});
    drain();

    // R5: last at boundary and exact fit: no disconnect
    send_txn(32'h0000_0600, 6, 0, acc, ret, dis);
    check(acc == 6 && !dis, "R5 last at boundary", {acc, 31'd0, dis}, {32'd6, 32'd0});
    send_txn(32'h0000_0700, 2, 0, acc, ret, dis);
    check(acc == 2 && !dis, "R5 last fills space", {acc, 31'd0, dis}, {32'd2, 32'd0});
    send_txn(32'h0000_0800, 1, 0, acc, ret, dis);
    check(ret, "R1 no slot left after exact fit", ret, 1);
    drain();

    // R9/R7: concurrent traffic with stalling output
    pace = 1;
    for (int k = 0; k < 14; k++)
      send_txn(32'h0001_0000 + 32'(k << 8), (k % 7) + 1, 1, acc, ret, dis);
    pace = 0;
    @(negedge clk_i);
    drain();

    finish_run();
  end
endmodule